// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers interrupt requests for a small 8-bit controller core and turns the most urgent one into a fixed program-memory vector address. It has six request sources: two periodic ticks that it derives from the core clock, two endpoint event pulses from a USB engine, a group of general-purpose pins, and one external timing pin. Every source has its own pending flag. A flag is set when its event occurs and holds until the core acknowledges that source's vector.

The core drives a global enable bit through a write strobe. The pin group is qualified by a per-pin enable mask and a per-pin polarity select. While the global enable is set and at least one flag is pending, the block raises its request and presents the vector of the winning source. When the core acknowledges, the block clears that source's flag and drops the global enable, so a handler is never interrupted by a second request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `irq_o` is 0, `vector_o` is 0x0000, the global enable is 0 and no source is pending.
- R2: A fast tick sets the slot-1 flag (vector 0x0002) once every FAST_DIV core cycles. A slow tick sets the slot-2 flag (vector 0x0004) once every FAST_DIV*SLOW_RATIO cycles. The defaults are 1536 and 8, which give 128 µs and 1.024 ms at 12 MHz. The first fast tick comes FAST_DIV cycles after reset.
- R3: The vector is twice the slot number. Endpoint 0 is slot 3 (0x0006), endpoint 1 is slot 4 (0x0008), the pin group is slot 6 (0x000C) and the external pin is slot 7 (0x000E). Slot 5 (0x000A) and slot 0 (0x0000) are never requested.
- R4: When more than one flag is pending, the vector with the lowest address is presented.
- R5: Each pin passes through a two-flop synchronizer. If its enable bit is 1, a synchronized transition sets the slot-6 flag. With polarity bit 1 a rising transition triggers, and with polarity bit 0 a falling transition triggers. A transition on a pin whose enable bit is 0 has no effect.
- R6: After the same synchronization, only a rising edge of the external pin sets the slot-7 flag.
- R7: A flag is latched even while the global enable is 0. It stays set until that source is acknowledged.
- R8: `irq_o` is 1 exactly when the global enable is 1 and at least one flag is pending. `vector_o` is 0x0000 whenever `irq_o` is 0.
- R9: An `ack_i` pulse while `irq_o` is 1 clears the flag of the presented source and clears the global enable. An `ack_i` pulse while `irq_o` is 0 has no effect.
- R10: If an event and the acknowledge that clears the same flag arrive in the same cycle, the flag stays set.
- R11: `gie_wr_i` loads `gie_wdata_i` into the global enable. A taken acknowledge in the same cycle wins and leaves the enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | PIN_W | Raw general-purpose pin levels |
| pin_en_i | input | PIN_W | Per-pin interrupt enable mask |
| pin_pol_i | input | PIN_W | Per-pin edge select, 1 rising, 0 falling |
| ext_pin_i | input | 1 | Raw external timing pin level |
| ep0_evt_i | input | 1 | Endpoint 0 event pulse |
| ep1_evt_i | input | 1 | Endpoint 1 event pulse |
| gie_wr_i | input | 1 | Global enable write strobe |
| gie_wdata_i | input | 1 | Global enable write value |
| ack_i | input | 1 | Acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | VEC_W | Vector address of the winning source |

## Verification
The bench builds the block with FAST_DIV of 12 and SLOW_RATIO of 4, and keeps PIN_W at 16. With these values the slow tick comes every 48 cycles. Several slow-tick periods therefore fit in a short run, and tick flags keep colliding with endpoint, pin and external events, which exercises the priority order and set-versus-clear races often. With only 12 cycles to the first tick, a directed sequence can run right after reset, before any tick is pending, and check vectors and acknowledge corner cases with exact values.

// File: rtl/irqv_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes vectors are 2 bytes apart, starting at program address zero.
package irqv_pkg;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int VEC_W     = 16;

    localparam int SLOT_FAST = 1;
    localparam int SLOT_SLOW = 2;
    localparam int SLOT_EP0  = 3;
    localparam int SLOT_EP1  = 4;
    localparam int SLOT_GPIO = 6;
    localparam int SLOT_EXT  = 7;

    // Slots that can hold a pending request (0 is reset, 5 reserved).
    localparam logic [NUM_SLOTS-1:0] SLOT_USED = 8'b1101_1110;

    typedef logic [NUM_SLOTS-1:0] slot_vec_t;

    // Program address of a slot's vector: two bytes per slot.
    function automatic logic [VEC_W-1:0] slot_addr(input logic [SLOT_W-1:0] s);
        slot_addr = VEC_W'({s, 1'b0});
    endfunction
endpackage

// File: rtl/irqv_tick_gen.sv
// Periodic tick source: a fast tick every FAST_DIV cycles and a slow tick
// on every SLOW_RATIO-th fast tick. Ticks are one-cycle pulses.
// Assumes FAST_DIV >= 2 and SLOW_RATIO >= 1.
module irqv_tick_gen #(
    parameter int FAST_DIV   = 1536,
    parameter int SLOW_RATIO = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_fast_o,
    output logic tick_slow_o
);
    localparam int FW = (FAST_DIV   > 1) ? $clog2(FAST_DIV)   : 1;
    localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
    localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);
    localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_RATIO - 1);

    logic [FW-1:0] fast_cnt;
    logic [SW-1:0] slow_cnt;

    assign tick_fast_o = (fast_cnt == FAST_LAST);
    assign tick_slow_o = tick_fast_o && (slow_cnt == SLOW_LAST);

    // Core-clock divider for the fast tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           fast_cnt <= '0;
        else if (tick_fast_o) fast_cnt <= '0;
        else                  fast_cnt <= fast_cnt + 1'b1;
    end

    // Counts fast ticks to form the slow tick.
    always_ff @(posedge clk) begin
        if (!rst_n)           slow_cnt <= '0;
        else if (tick_slow_o) slow_cnt <= '0;
        else if (tick_fast_o) slow_cnt <= slow_cnt + 1'b1;
    end
endmodule

// File: rtl/irqv_edge_detect.sv
// Per-bit two-flop synchronizer followed by an edge detector with a
// selectable polarity (1 rising, 0 falling) and an enable per bit.
// Assumes inputs are asynchronous levels; edges are one-cycle pulses.
module irqv_edge_detect #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] edge_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        // Synchronize the raw level and keep its previous value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= level_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Select the qualifying transition for this bit.
        always_comb begin
            if (pol_i[g]) edge_o[g] = en_i[g] & sync_q & ~prev_q;
            else          edge_o[g] = en_i[g] & ~sync_q & prev_q;
        end
    end
endmodule

// File: rtl/irqv_pending_arb.sv
// Pending flags for every vector slot, a lowest-slot-first arbiter and the
// acknowledge path. A set in the same cycle as a clear keeps the flag.
// Assumes set pulses come from synchronous logic.
module irqv_pending_arb
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  slot_vec_t        set_i,
    input  logic             gie_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o
);
    slot_vec_t         pend_q;
    slot_vec_t         win;
    slot_vec_t         clr;
    logic [SLOT_W-1:0] win_idx;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (SLOT_USED[s]) begin : g_used
            // Latch the event, release on acknowledge of this slot.
            always_ff @(posedge clk) begin
                if (!rst_n)        pend_q[s] <= 1'b0;
                else if (set_i[s]) pend_q[s] <= 1'b1;
                else if (clr[s])   pend_q[s] <= 1'b0;
            end
        end else begin : g_unused
            assign pend_q[s] = 1'b0;
        end
    end

    // Isolate the lowest pending slot and encode it.
    always_comb begin
        win     = pend_q & (~pend_q + 1'b1);
        win_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (pend_q[i]) win_idx = SLOT_W'(i);
        end
    end

    // Request, vector and acknowledge qualification.
    always_comb begin
        irq_o    = gie_i && (|pend_q);
        take_o   = ack_i && irq_o;
        clr      = take_o ? win : '0;
        vector_o = irq_o ? slot_addr(win_idx) : '0;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the vectored interrupt controller: tick generation, pin and
// external-pin edge capture, global enable and pending arbitration.
// Assumes a single core clock; ack_i is a one-cycle pulse from the core.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int FAST_DIV   = 1536,
    parameter int SLOW_RATIO = 8,
    parameter int PIN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [PIN_W-1:0] pin_en_i,
    input  logic [PIN_W-1:0] pin_pol_i,
    input  logic             ext_pin_i,
    input  logic             ep0_evt_i,
    input  logic             ep1_evt_i,
    input  logic             gie_wr_i,
    input  logic             gie_wdata_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vector_o
);
    logic             tick_fast;
    logic             tick_slow;
    logic [PIN_W-1:0] gpio_edge;
    logic [0:0]       ext_edge;
    slot_vec_t        set_vec;
    logic             gie_q;
    logic             take;

    irqv_tick_gen #(
        .FAST_DIV  (FAST_DIV),
        .SLOW_RATIO(SLOW_RATIO)
    ) u_ticks (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_fast_o(tick_fast),
        .tick_slow_o(tick_slow)
    );

    irqv_edge_detect #(.WIDTH(PIN_W)) u_gpio_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(pins_i),
        .en_i   (pin_en_i),
        .pol_i  (pin_pol_i),
        .edge_o (gpio_edge)
    );

    irqv_edge_detect #(.WIDTH(1)) u_ext_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(ext_pin_i),
        .en_i   (1'b1),
        .pol_i  (1'b1),
        .edge_o (ext_edge)
    );

    // Route every event onto its vector slot.
    always_comb begin
        set_vec            = '0;
        set_vec[SLOT_FAST] = tick_fast;
        set_vec[SLOT_SLOW] = tick_slow;
        set_vec[SLOT_EP0]  = ep0_evt_i;
        set_vec[SLOT_EP1]  = ep1_evt_i;
        set_vec[SLOT_GPIO] = |gpio_edge;
        set_vec[SLOT_EXT]  = ext_edge[0];
    end

    // Global enable: a taken interrupt clears it ahead of any write.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie_q <= 1'b0;
        else if (take)     gie_q <= 1'b0;
        else if (gie_wr_i) gie_q <= gie_wdata_i;
    end

    irqv_pending_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .gie_i   (gie_q),
        .ack_i   (ack_i),
        .irq_o   (irq_o),
        .take_o  (take),
        .vector_o(vector_o)
    );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Property checker for irq_vector_ctrl, attached with bind below.
module irq_vector_ctrl_chk
    import irqv_pkg::*;
#(
    parameter int FAST_DIV = 1536
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [VEC_W-1:0] vector_o,
    input logic             ack_i,
    input logic             gie_wr_i,
    input logic             gie_q,
    input logic             tick_fast
);
    int unsigned since_tick;

    // Cycles since reset or since the last fast tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         since_tick <= 0;
        else if (tick_fast) since_tick <= 0;
        else                since_tick <= since_tick + 1;
    end

    // R3: the reserved slot and the reset slot never appear as a request.
    a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o != 16'h000A && vector_o != 16'h0000));

    // R3: every presented vector is even and inside the 16-byte table.
    a_r3_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o[0] == 1'b0 && vector_o <= 16'h000E));

    // R8: no request while the global enable is clear.
    a_r8_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_q);

    // R8: no vector without a request.
    a_r8_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vector_o == '0);

    // R9: a taken acknowledge drops the request in the next cycle.
    a_r9_ack_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !irq_o);

    // R7: a request holds until acknowledged or the enable is rewritten.
    a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !gie_wr_i) |=> irq_o);

    // R2: fast ticks are exactly FAST_DIV cycles apart.
    a_r2_fast_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fast == (since_tick == FAST_DIV - 1));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.FAST_DIV(FAST_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .vector_o (vector_o),
    .ack_i    (ack_i),
    .gie_wr_i (gie_wr_i),
    .gie_q    (gie_q),
    .tick_fast(tick_fast)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int FAST_DIV   = 12;
    localparam int SLOW_RATIO = 4;
    localparam int PIN_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [PIN_W-1:0] pins_i, pin_en_i, pin_pol_i;
    logic             ext_pin_i, ep0_evt_i, ep1_evt_i;
    logic             gie_wr_i, gie_wdata_i, ack_i;
    logic             irq_o;
    logic [15:0]      vector_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int seen_fast = 0, seen_slow = 0, seen_gpio = 0, seen_ext = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl #(
        .FAST_DIV  (FAST_DIV),
        .SLOW_RATIO(SLOW_RATIO),
        .PIN_W     (PIN_W)
    ) u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .pin_en_i(pin_en_i),
        .pin_pol_i(pin_pol_i), .ext_pin_i(ext_pin_i), .ep0_evt_i(ep0_evt_i),
        .ep1_evt_i(ep1_evt_i), .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i),
        .ack_i(ack_i), .irq_o(irq_o), .vector_o(vector_o)
    );

    // ---------------- reference model built from the requirements ----------
    logic [7:0]       m_pend;
    logic             m_gie;
    int               m_fcnt, m_scnt;
    logic [PIN_W-1:0] m_s1, m_s2, m_pv;
    logic             m_e1, m_e2, m_ep;

    function automatic int low_slot(input logic [7:0] p);
        for (int i = 0; i < 8; i++) if (p[i]) return i;
        return 0;
    endfunction

    function automatic logic [15:0] exp_vector(input logic [7:0] p, input logic g);
        if (!(g && (p != 0))) return 16'h0000;
        return 16'(low_slot(p) * 2);
    endfunction

    wire m_irq  = m_gie && (m_pend != 0);
    wire m_take = ack_i && m_irq;

    always @(posedge clk) begin
        logic [7:0] set;
        logic [PIN_W-1:0] edg;
        if (!rst_n) begin
            m_pend <= '0; m_gie <= 1'b0; m_fcnt <= 0; m_scnt <= 0;
            m_s1 <= '0; m_s2 <= '0; m_pv <= '0;
            m_e1 <= 1'b0; m_e2 <= 1'b0; m_ep <= 1'b0;
        end else begin
            set = '0;
            if (m_fcnt == FAST_DIV - 1) begin
                set[1] = 1'b1;
                if (m_scnt == SLOW_RATIO - 1) set[2] = 1'b1;
            end
            set[3] = ep0_evt_i;
            set[4] = ep1_evt_i;
            for (int i = 0; i < PIN_W; i++)
                edg[i] = pin_en_i[i] && (pin_pol_i[i] ? (m_s2[i] && !m_pv[i])
                                                      : (!m_s2[i] && m_pv[i]));
            set[6] = |edg;
            set[7] = m_e2 && !m_ep;
            m_fcnt <= (m_fcnt == FAST_DIV - 1) ? 0 : m_fcnt + 1;
            if (m_fcnt == FAST_DIV - 1)
                m_scnt <= (m_scnt == SLOW_RATIO - 1) ? 0 : m_scnt + 1;
            m_s1 <= pins_i; m_s2 <= m_s1; m_pv <= m_s2;
            m_e1 <= ext_pin_i; m_e2 <= m_e1; m_ep <= m_e2;
            m_pend <= (m_pend & ~(m_take ? (8'd1 << low_slot(m_pend)) : 8'd0)) | set;
            if (m_take)        m_gie <= 1'b0;
            else if (gie_wr_i) m_gie <= gie_wdata_i;
        end
    end

    // ---------------- checking helpers --------------------------------------
    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Compare outputs with the model, then hold inputs at their idle values.
    task automatic step_compare(input string tag);
        logic [15:0] ev;
        ev = exp_vector(m_pend, m_gie);
        check(irq_o == m_irq && vector_o == ev, tag,
              {15'd0, irq_o, vector_o}, {15'd0, m_irq, ev});
        if (irq_o) begin
            if (vector_o == 16'h0002) seen_fast++;
            if (vector_o == 16'h0004) seen_slow++;
            if (vector_o == 16'h000C) seen_gpio++;
            if (vector_o == 16'h000E) seen_ext++;
        end
    endtask

    task automatic idle_inputs();
        ep0_evt_i = 0; ep1_evt_i = 0; gie_wr_i = 0; gie_wdata_i = 0; ack_i = 0;
    endtask

    task automatic expect_out(input string tag, input logic irq_e, input logic [15:0] vec_e);
        check(irq_o == irq_e && vector_o == vec_e, tag,
              {15'd0, irq_o, vector_o}, {15'd0, irq_e, vec_e});
    endtask

    // ---------------- watchdog ----------------------------------------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            finish_run();
        end
    end

    // ---------------- stimulus ----------------------------------------------
    initial begin
        void'($urandom(32'd7331));
        rst_n = 0; pins_i = '0; pin_en_i = '0; pin_pol_i = '0; ext_pin_i = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        expect_out("R1 reset outputs", 1'b0, 16'h0000);
        // Directed sequence: 12 cycles before the first tick is pending.
        rst_n = 1;
        expect_out("R1 first cycle", 1'b0, 16'h0000);
        ep1_evt_i = 1;                                    // n=0
        @(negedge clk); idle_inputs();                    // n=1
        expect_out("R7 masked but latched", 1'b0, 16'h0000);
        gie_wr_i = 1; gie_wdata_i = 1;
        @(negedge clk); idle_inputs();                    // n=2
        expect_out("R3 R11 ep1 vector", 1'b1, 16'h0008);
        ep0_evt_i = 1;
        @(negedge clk); idle_inputs();                    // n=3
        expect_out("R4 ep0 outranks ep1", 1'b1, 16'h0006);
        ack_i = 1;
        @(negedge clk); idle_inputs();                    // n=4
        expect_out("R9 ack drops enable", 1'b0, 16'h0000);
        gie_wr_i = 1; gie_wdata_i = 1;
        @(negedge clk); idle_inputs();                    // n=5
        expect_out("R9 ep0 cleared only", 1'b1, 16'h0008);
        ack_i = 1; ep1_evt_i = 1;
        @(negedge clk); idle_inputs();                    // n=6
        expect_out("R10 enable off after ack", 1'b0, 16'h0000);
        gie_wr_i = 1; gie_wdata_i = 1;
        @(negedge clk); idle_inputs();                    // n=7
        expect_out("R10 set beats clear", 1'b1, 16'h0008);
        ack_i = 1; gie_wr_i = 1; gie_wdata_i = 1;
        @(negedge clk); idle_inputs();                    // n=8
        expect_out("R11 ack beats write", 1'b0, 16'h0000);
        ep0_evt_i = 1;
        @(negedge clk); idle_inputs();                    // n=9
        ack_i = 1;
        @(negedge clk); idle_inputs();                    // n=10
        gie_wr_i = 1; gie_wdata_i = 1;
        @(negedge clk); idle_inputs();                    // n=11
        expect_out("R9 ack ignored when idle", 1'b1, 16'h0006);
        ack_i = 1;
        // Disabled pin: a transition must not set the pin flag.
        pin_en_i = 16'h0001; pin_pol_i = 16'hFFFF;
        pins_i = 16'h0002;
        repeat (2) begin
            @(negedge clk); idle_inputs();
        end
        gie_wr_i = 1; gie_wdata_i = 1;
        repeat (FAST_DIV * SLOW_RATIO * 2) begin
            @(negedge clk);
            step_compare("R2 R4 R8 tick stream");
            idle_inputs();
            if (irq_o) begin
                check(vector_o != 16'h000C, "R5 disabled pin ignored",
                      {16'd0, vector_o}, 32'h0000_0000);
                ack_i = 1; gie_wr_i = 1; gie_wdata_i = 1;
            end
        end
        // Random phase.
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            step_compare("R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
            idle_inputs();
            if (c % 400 == 0) begin
                pin_en_i  = 16'($urandom);
                pin_pol_i = 16'($urandom);
            end
            if ($urandom_range(0, 7) == 0) pins_i[$urandom_range(0, PIN_W - 1)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) ext_pin_i = ~ext_pin_i;
            ep0_evt_i = ($urandom_range(0, 29) == 0);
            ep1_evt_i = ($urandom_range(0, 29) == 0);
            if ($urandom_range(0, 5) == 0) begin
                gie_wr_i = 1; gie_wdata_i = ($urandom_range(0, 3) != 0);
            end
            if (irq_o && $urandom_range(0, 1) == 0) ack_i = 1;
            else if ($urandom_range(0, 40) == 0) ack_i = 1;
        end
        check(seen_fast > 0, "R2 fast vector seen", 32'(seen_fast), 32'd1);
        check(seen_slow > 0, "R2 slow vector seen", 32'(seen_slow), 32'd1);
        check(seen_gpio > 0, "R5 pin vector seen",  32'(seen_gpio), 32'd1);
        check(seen_ext  > 0, "R6 ext vector seen",  32'(seen_ext),  32'd1);
        done = 1'b1;
        finish_run();
    end
endmodule